// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request interface to an external asynchronous static RAM. The RAM has one bidirectional data bus and three active-low strobes: chip select, write enable and output enable. A user issues one read or one write at a time. Each request carries a direction flag, an address and write data, and is handed over with a valid/ready handshake. Read data comes back on its own port, qualified by a single-cycle valid pulse.

Every signal that crosses the pad boundary is a register output. This includes the outgoing data, the enable of the bus drivers and the incoming data. The controller only ever looks at its own registered copy of the bus, never at the raw pins. This costs a fixed cycle of capture latency on reads. In return, the pad timing does not depend on any internal logic path.

The strobe pulse widths are set by parameters (`WR_CYCLES`, `RD_CYCLES`). After each access the controller spends one cycle with all strobes inactive before it takes the next request. This keeps the two sides from driving the bus at the same time when its direction changes.

Top module: `asram_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, the controller does not drive `sram_dq`, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access's closing idle cycle has passed. It is 1 again in the cycle after that closing cycle.
- R3: A write (`req_write` = 1) holds `sram_cs_n` = 0, `sram_we_n` = 0 and `sram_oe_n` = 1 for exactly `WR_CYCLES` consecutive cycles, starting in the cycle after acceptance.
- R4: Throughout a write strobe, `sram_addr` shows the accepted address and `sram_dq` shows the accepted data. `sram_we_n` returns to 1 one cycle before the controller releases the bus, so the data stays driven through that cycle.
- R5: The controller drives `sram_dq` only in cycles where `sram_oe_n` is 1 and a write is in progress. In every other cycle all bits are at high impedance.
- R6: A read (`req_write` = 0) holds `sram_cs_n` = 0, `sram_oe_n` = 0 and `sram_we_n` = 1 for exactly `RD_CYCLES` consecutive cycles, starting in the cycle after acceptance. `sram_addr` shows the accepted address throughout.
- R7: `sram_dq` is sampled into a capture register on every rising edge. In the cycle right after the last read strobe cycle, `rsp_valid` is 1 for exactly one cycle. At the same time, `rsp_rdata` shows the bus value sampled at the edge that closed the strobe.
- R8: Each access is followed by at least one cycle with all three strobes at 1. A write strobe never directly follows a read strobe, and a read strobe never directly follows a write strobe.
- R9: While `req_ready` is 0, `req_valid` has no effect. The running access keeps its address, direction and data, and no second access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data qualifier |
| rsp_rdata | output | DATA_W | Read data from the capture register |
| sram_addr | output | ADDR_W | Registered RAM address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
If the sequencer state or its pulse counter is wrong, the strobe widths at the pins change within the same access. A read or write strobe then becomes one cycle short or long, or `req_ready` comes back early. If the drive-enable register slips out of step with the strobes, the released-bus probe catches it in the first cycle after a write: the bus is still being driven there, or it is already floating during the write-enable low window. If the capture path is stale or has the wrong timing, the value returned with `rsp_valid` on the very next read disagrees with the reference memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR     = 3'd1,
    ST_WR_END = 3'd2,
    ST_RD     = 3'd3,
    ST_RD_END = 3'd4
  } asram_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
  } asram_strobe_t;

  localparam asram_strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  // Asserts immediately, deasserts after STAGES rising edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WR_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              wdata_load,
  output logic              drive_nxt,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output asram_strobe_t     strobe
);

  localparam int MAX_CYC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);

  asram_state_e     state_q, state_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [ADDR_W-1:0] addr_q;
  asram_strobe_t    strobe_q, strobe_nxt;
  logic             accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Next-state and pulse-width counter.
  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_nxt = req_write ? ST_WR : ST_RD;
          cnt_nxt   = req_write ? WR_LOAD : RD_LOAD;
        end
      end
      ST_WR: begin
        if (cnt_q == '0) state_nxt = ST_WR_END;
        else             cnt_nxt   = cnt_q - 1'b1;
      end
      ST_RD: begin
        if (cnt_q == '0) state_nxt = ST_RD_END;
        else             cnt_nxt   = cnt_q - 1'b1;
      end
      ST_WR_END: state_nxt = ST_IDLE;
      ST_RD_END: state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  // Strobe levels for the coming cycle, decoded from the next state.
  always_comb begin
    strobe_nxt = STROBE_IDLE;
    if (state_nxt == ST_WR) begin
      strobe_nxt.cs_n = 1'b0;
      strobe_nxt.we_n = 1'b0;
    end else if (state_nxt == ST_RD) begin
      strobe_nxt.cs_n = 1'b0;
      strobe_nxt.oe_n = 1'b0;
    end
  end

  // Write data is driven through the strobe and one hold cycle after it.
  assign drive_nxt  = (state_nxt == ST_WR) || (state_nxt == ST_WR_END);
  assign wdata_load = accept && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      strobe_q <= STROBE_IDLE;
    end else begin
      state_q  <= state_nxt;
      cnt_q    <= cnt_nxt;
      strobe_q <= strobe_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign sram_addr = addr_q;
  assign strobe    = strobe_q;
  assign rsp_valid = (state_q == ST_RD_END);

endmodule

// File: rtl/asram_pad.sv
module asram_pad #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdata_load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_nxt,
  output logic              drive_o,
  output logic [DATA_W-1:0] cap_o,
  inout  wire  [DATA_W-1:0] dq
);

  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] cap_q;
  logic              drive_q;

  // Output data, driver enable and input capture: one flop each at the pad.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      drive_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      drive_q <= drive_nxt;
      cap_q   <= dq;
      if (wdata_load) dout_q <= wdata;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign dq[i] = drive_q ? dout_q[i] : 1'bz;
  end

  assign drive_o = drive_q;
  assign cap_o   = cap_q;

endmodule

// File: rtl/asram_bus_ctrl.sv
module asram_bus_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  inout  wire  [DATA_W-1:0] sram_dq
);

  logic          rst_n_int;
  logic          wdata_load;
  logic          drive_nxt;
  logic          bus_drive;
  asram_strobe_t strobe;

  asram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_int)
  );

  asram_seq #(
    .ADDR_W   (ADDR_W),
    .WR_CYCLES(WR_CYCLES),
    .RD_CYCLES(RD_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .wdata_load(wdata_load),
    .drive_nxt (drive_nxt),
    .rsp_valid (rsp_valid),
    .sram_addr (sram_addr),
    .strobe    (strobe)
  );

  asram_pad #(.DATA_W(DATA_W)) u_pad (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wdata_load(wdata_load),
    .wdata     (req_wdata),
    .drive_nxt (drive_nxt),
    .drive_o   (bus_drive),
    .cap_o     (rsp_rdata),
    .dq        (sram_dq)
  );

  assign sram_cs_n = strobe.cs_n;
  assign sram_we_n = strobe.we_n;
  assign sram_oe_n = strobe.oe_n;

endmodule

// File: rtl/asram_bus_chk.sv
module asram_bus_chk #(
  parameter int ADDR_W    = 10,
  parameter int WR_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              bus_drive
);

  logic [15:0] we_run_q;
  logic [15:0] oe_run_q;

  // Length of the current low pulse on each strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= sram_we_n ? 16'd0 : we_run_q + 16'd1;
      oe_run_q <= sram_oe_n ? 16'd0 : oe_run_q + 16'd1;
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !req_ready);

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_run_q == 16'(WR_CYCLES)));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  p_we_before_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_drive) |-> $past(sram_we_n));

  p_drive_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> sram_oe_n);

  p_oe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_run_q == 16'(RD_CYCLES)));

  p_valid_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $past(sram_oe_n));

  p_no_read_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> $past(sram_we_n));

endmodule

bind asram_bus_ctrl asram_bus_chk #(
  .ADDR_W   (ADDR_W),
  .WR_CYCLES(WR_CYCLES),
  .RD_CYCLES(RD_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .sram_addr(sram_addr),
  .sram_cs_n(sram_cs_n),
  .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n),
  .bus_drive(bus_drive)
);

// File: tb/tb_asram_bus_ctrl.sv
module tb_asram_bus_ctrl;

  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 8;
  localparam int WR_CYCLES = 2;
  localparam int RD_CYCLES = 2;
  localparam int DEPTH     = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] sram_addr;
  logic              sram_cs_n;
  logic              sram_we_n;
  logic              sram_oe_n;
  wire  [DATA_W-1:0] sram_dq;

  logic [DATA_W-1:0] ram   [DEPTH];
  logic [DATA_W-1:0] ref_m [DEPTH];
  logic              probe_en;
  logic [DATA_W-1:0] probe_val;

  int checks;
  int errors;

  asram_bus_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WR_CYCLES(WR_CYCLES), .RD_CYCLES(RD_CYCLES)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
  );

  // Simple RAM responder and a probe driver used to detect a released bus.
  assign sram_dq = (!sram_cs_n && !sram_oe_n && sram_we_n) ? ram[sram_addr] : 'z;
  assign sram_dq = probe_en ? probe_val : 'z;

  always @(posedge clk) begin
    if (!sram_cs_n && !sram_we_n) ram[sram_addr] <= sram_dq;
  end

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] init_val(input int a);
    return DATA_W'(a * 37 + 5);
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    return ref_m[a];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a value on the bus for one sample; a controller still driving corrupts it.
  task automatic probe_released(input logic [DATA_W-1:0] v, input string req);
    probe_val = v;
    probe_en  = 1'b1;
    #1;
    check(sram_dq == v, req, int'(sram_dq), int'(v));
    probe_en  = 1'b0;
  endtask

  task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input bit poke);
    int n;
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    check(req_ready == 1'b1, "R2 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (poke) begin
      req_addr = a ^ ADDR_W'(1); req_write = !wr; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (!sram_cs_n && n < 64) begin
      check(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
      if (wr) begin
        check(!sram_we_n && sram_oe_n, "R3 write strobes",
              int'({sram_we_n, sram_oe_n}), 1);
        check(sram_addr == a, "R4 write addr", int'(sram_addr), int'(a));
        check(sram_dq == d, "R4 write data", int'(sram_dq), int'(d));
      end else begin
        check(sram_we_n && !sram_oe_n, "R6 read strobes",
              int'({sram_we_n, sram_oe_n}), 2);
        check(sram_addr == a, "R6 read addr", int'(sram_addr), int'(a));
      end
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (wr) check(n == WR_CYCLES, "R3 write width", n, WR_CYCLES);
    else    check(n == RD_CYCLES, "R6 read width", n, RD_CYCLES);
    // Closing idle cycle.
    check(sram_cs_n && sram_we_n && sram_oe_n, "R8 idle gap",
          int'({sram_cs_n, sram_we_n, sram_oe_n}), 7);
    check(req_ready == 1'b0, "R2 busy in closing cycle", int'(req_ready), 0);
    if (wr) begin
      check(sram_dq == d, "R4 data held after we rise", int'(sram_dq), int'(d));
      check(rsp_valid == 1'b0, "R7 no valid on write", int'(rsp_valid), 0);
      ref_m[a] = d;
    end else begin
      check(rsp_valid == 1'b1, "R7 valid pulse", int'(rsp_valid), 1);
      check(rsp_rdata == exp_read(a), "R7 read data", int'(rsp_rdata), int'(exp_read(a)));
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready back", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R7 single cycle valid", int'(rsp_valid), 0);
    probe_released(~d | DATA_W'(1), "R5 bus released");
    if (poke) begin
      check(sram_cs_n == 1'b1, "R9 busy request ignored", int'(sram_cs_n), 1);
      check(ref_m[a ^ ADDR_W'(1)] == ram[a ^ ADDR_W'(1)], "R9 neighbour untouched",
            int'(ram[a ^ ADDR_W'(1)]), int'(ref_m[a ^ ADDR_W'(1)]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]   = init_val(i);
      ref_m[i] = init_val(i);
    end
    probe_en = 1'b0; probe_val = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes in reset",
          int'({sram_cs_n, sram_we_n, sram_oe_n}), 7);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 valid in reset", int'(rsp_valid), 0);
    probe_released(8'hA5, "R1 bus released in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes after reset",
          int'({sram_cs_n, sram_we_n, sram_oe_n}), 7);
    probe_released(8'h5A, "R1 bus released after reset");

    // Directed corners: address extremes, write then read back-to-back.
    do_op(1'b1, '0, 8'h3C, 1'b0);
    do_op(1'b0, '0, 8'h00, 1'b0);
    do_op(1'b1, '1, 8'hFF, 1'b0);
    do_op(1'b0, '1, 8'h00, 1'b0);
    do_op(1'b0, ADDR_W'(17), 8'h00, 1'b0);
    // R9: requests while busy are ignored.
    do_op(1'b1, ADDR_W'(100), 8'h81, 1'b1);
    do_op(1'b0, ADDR_W'(100), 8'h00, 1'b1);
    do_op(1'b0, ADDR_W'(101), 8'h00, 1'b0);

    for (int k = 0; k < 300; k++) begin
      do_op(1'($urandom % 2), ADDR_W'($urandom % DEPTH), DATA_W'($urandom), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule